// File: doc/BRIEF.md
# Bus Clock Divider and Gating Unit

This block turns one main clock into a set of synchronous clock-enable pulses: one shared by the CPU and the AHB bus, and one for each of three APB buses. Every stage divides by a power of two picked by a 3-bit code. The APB stages divide the main-stage pulse train further, so an APB bus runs at the main-stage rate shifted right by its own code. No derived clocks are made. Logic downstream stays on the main clock and qualifies its registers with these enables.

Each bus also has a mask of per-peripheral gates. A peripheral's enable pulses only when its bus pulses and its mask bit is 1. Software changes the masks through two write operations. A set write ORs bits in, and a clear write removes bits. Neither operation disturbs bits written as zero, so two agents can change separate peripherals without a read-modify-write.

A new divider code is held until the stage's counter wraps. Because of this, a switch never produces a period shorter than the old or new ratio. Writes with an unknown bus selector or operation are refused and flagged.

Top module: `busclk_gate_unit`

## Requirements
- R1: The main-stage code n (0..7) makes `cpu_ce` pulse once every 2^n main-clock cycles.
- R2: `ahb_ce` is identical to `cpu_ce` in every cycle.
- R3: APB bus k (A=0, B=1, C=2) has its own code a. `apb_ce[k]` pulses once every 2^(n+a) main-clock cycles, and only in cycles where `cpu_ce` pulses.
- R4: A set write (`wr_op`=0) ORs `wr_data` into the selected bus's mask. Zero bits in `wr_data` leave the mask unchanged.
- R5: A clear write (`wr_op`=1) clears each mask bit that is 1 in `wr_data`. Zero bits in `wr_data` leave the mask unchanged.
- R6: Each per-peripheral enable bit equals the bus enable ANDed with that bit of the bus's mask. A peripheral with mask bit 0 never receives a pulse.
- R7: Selector `wr_sel` 0 addresses the main/AHB stage, and 1, 2, 3 address APB A, B, C. A code write (`wr_op`=2) takes the low 3 bits of `wr_data`. A write with `wr_sel` 4..7 or `wr_op`=3 changes no mask and no code, and `wr_err` is 1 in the following cycle. After an accepted write, `wr_err` is 0.
- R8: A new code takes effect only at the next wrap of the 7-bit counter of its stage. Every interval between consecutive pulses equals either the old period or the new one.
- R9: After reset all codes are 0 and all masks are all ones. Every per-peripheral enable therefore pulses in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_op | input | 2 | 0 set mask, 1 clear mask, 2 write divider code, 3 reserved |
| wr_sel | input | 3 | Bus selector: 0 main/AHB, 1 APB A, 2 APB B, 3 APB C |
| wr_data | input | MASK_W | Mask bits, or a divider code in bits [2:0] |
| wr_err | output | 1 | Previous-cycle write was rejected |
| cpu_ce | output | 1 | CPU clock enable |
| ahb_ce | output | 1 | AHB clock enable |
| apb_ce | output | 3 | APB A/B/C clock enables |
| ahb_per_ce | output | MASK_W | Gated AHB peripheral enables |
| apba_per_ce | output | MASK_W | Gated APB A peripheral enables |
| apbb_per_ce | output | MASK_W | Gated APB B peripheral enables |
| apbc_per_ce | output | MASK_W | Gated APB C peripheral enables |

## Verification
The dividers are measured as pulse-to-pulse intervals for main codes 0, 2, 3 and 7. These cases separate a correct shift from an off-by-one or a stuck code. The APB codes are measured as 2, 0 and 3 on top of a nonzero main code, which shows that each bus composes with the main ratio and not with a neighbour's. Mask writes are tried with all-ones, sparse and all-zero data on different buses. This separates OR from overwrite and AND-NOT from plain clear, and it exposes writes routed to the wrong bus. A code switch from ratio 2 to ratio 8 is watched over many pulses to catch any shortened interval.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  // Bus slots addressed by the selector; order is decoded by wr_sel
  localparam int NBUS       = 4;
  localparam int NAPB       = 3;
  localparam int DEF_MASK_W = 8;
  localparam int DEF_CNT_W  = 7;
  localparam int SEL_W      = 3;

  typedef enum logic [1:0] {
    OP_SET  = 2'd0,
    OP_CLR  = 2'd1,
    OP_CODE = 2'd2,
    OP_RSV  = 2'd3
  } wr_op_e;

  // Mask of the n lowest bits; the stage pulses when these are all ones
  function automatic int unsigned low_ones(input int unsigned n);
    return (32'd1 << n) - 32'd1;
  endfunction

  // Next mask value after one set or clear write
  function automatic logic [DEF_MASK_W-1:0] mask_next(
    input logic [DEF_MASK_W-1:0] cur,
    input logic                  do_set,
    input logic                  do_clr,
    input logic [DEF_MASK_W-1:0] bits
  );
    logic [DEF_MASK_W-1:0] r;
    r = cur;
    if (do_set) r = r | bits;
    if (do_clr) r = r & ~bits;
    return r;
  endfunction

endpackage

// File: rtl/bcg_wr_decode.sv
module bcg_wr_decode
  import bcg_pkg::*;
#(
  parameter int NB = NBUS,
  parameter int SW = SEL_W
) (
  input  logic          wr_en,
  input  logic [1:0]    wr_op,
  input  logic [SW-1:0] wr_sel,
  output logic [NB-1:0] set_we,
  output logic [NB-1:0] clr_we,
  output logic [NB-1:0] code_we,
  output logic          bad
);

  wr_op_e op;
  logic   sel_ok;

  assign op     = wr_op_e'(wr_op);
  assign sel_ok = (int'(wr_sel) < NB);

  always_comb begin
    set_we  = '0;
    clr_we  = '0;
    code_we = '0;
    bad     = wr_en && (!sel_ok || op == OP_RSV);
    if (wr_en && !bad) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_sel == SW'(b)) begin
          set_we[b]  = (op == OP_SET);
          clr_we[b]  = (op == OP_CLR);
          code_we[b] = (op == OP_CODE);
        end
      end
    end
  end

endmodule

// File: rtl/bcg_rate_stage.sv
module bcg_rate_stage
  import bcg_pkg::*;
#(
  parameter int CNT_W  = DEF_CNT_W,
  parameter int CODE_W = $clog2(CNT_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              code_we,
  input  logic [CODE_W-1:0] code_in,
  output logic              ce
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] pend_q;
  logic [CODE_W-1:0] act_q;
  logic [CNT_W-1:0]  sel_bits;
  logic              wrap;

  assign sel_bits = CNT_W'(low_ones(int'(act_q)));
  assign wrap     = step && (cnt_q == CNT_TOP);
  assign ce       = step && ((cnt_q & sel_bits) == sel_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (code_we) pend_q <= code_in;
      if (step)    cnt_q  <= cnt_q + CNT_W'(1);
      // counter at all ones is a pulse for every code: safe switch point
      if (wrap)    act_q  <= pend_q;
    end
  end

endmodule

// File: rtl/bcg_mask_bank.sv
module bcg_mask_bank
  import bcg_pkg::*;
#(
  parameter int W = DEF_MASK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  input  logic         bus_ce,
  output logic [W-1:0] mask,
  output logic [W-1:0] per_ce
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               mask <= '1;
    else if (set_we || clr_we) mask <= mask_next(mask, set_we, clr_we, bits);
  end

  assign per_ce = mask & {W{bus_ce}};

endmodule

// File: rtl/busclk_gate_unit.sv
module busclk_gate_unit
  import bcg_pkg::*;
#(
  parameter int MASK_W = DEF_MASK_W,
  parameter int CNT_W  = DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_op,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [MASK_W-1:0] wr_data,
  output logic              wr_err,
  output logic              cpu_ce,
  output logic              ahb_ce,
  output logic [NAPB-1:0]   apb_ce,
  output logic [MASK_W-1:0] ahb_per_ce,
  output logic [MASK_W-1:0] apba_per_ce,
  output logic [MASK_W-1:0] apbb_per_ce,
  output logic [MASK_W-1:0] apbc_per_ce
);

  localparam int CODE_W = $clog2(CNT_W + 1);

  // named internal events, also watched by the bound checker
  logic [NBUS-1:0]             set_we;
  logic [NBUS-1:0]             clr_we;
  logic [NBUS-1:0]             code_we;
  logic                        wr_bad;
  logic [NBUS-1:0]             bus_ce;
  logic [NBUS-1:0][MASK_W-1:0] mask_q;
  logic [NBUS-1:0][MASK_W-1:0] per_ce;
  logic [CODE_W-1:0]           code_in;

  assign code_in = wr_data[CODE_W-1:0];

  bcg_wr_decode #(.NB(NBUS), .SW(SEL_W)) u_dec (
    .wr_en   (wr_en),
    .wr_op   (wr_op),
    .wr_sel  (wr_sel),
    .set_we  (set_we),
    .clr_we  (clr_we),
    .code_we (code_we),
    .bad     (wr_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= wr_bad;
  end

  // main stage: advances every clock
  bcg_rate_stage #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_main (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (1'b1),
    .code_we (code_we[0]),
    .code_in (code_in),
    .ce      (bus_ce[0])
  );

  // APB stages: advance only on main-stage pulses
  for (genvar k = 0; k < NAPB; k++) begin : g_apb
    bcg_rate_stage #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_apb (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (bus_ce[0]),
      .code_we (code_we[k+1]),
      .code_in (code_in),
      .ce      (bus_ce[k+1])
    );
  end

  for (genvar b = 0; b < NBUS; b++) begin : g_mask
    bcg_mask_bank #(.W(MASK_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (set_we[b]),
      .clr_we (clr_we[b]),
      .bits   (wr_data),
      .bus_ce (bus_ce[b]),
      .mask   (mask_q[b]),
      .per_ce (per_ce[b])
    );
  end

  assign cpu_ce      = bus_ce[0];
  assign ahb_ce      = bus_ce[0];
  assign apb_ce      = bus_ce[NBUS-1:1];
  assign ahb_per_ce  = per_ce[0];
  assign apba_per_ce = per_ce[1];
  assign apbb_per_ce = per_ce[2];
  assign apbc_per_ce = per_ce[3];

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker
  import bcg_pkg::*;
#(
  parameter int W = DEF_MASK_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NBUS-1:0]        set_we,
  input logic [NBUS-1:0]        clr_we,
  input logic                   wr_bad,
  input logic [W-1:0]           wr_data,
  input logic [NBUS-1:0][W-1:0] mask_q,
  input logic                   wr_err,
  input logic                   cpu_ce,
  input logic [NAPB-1:0]        apb_ce,
  input logic [W-1:0]           ahb_per_ce
);

  // R3
  apb_inside_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apb_ce != '0) |-> cpu_ce);

  // R6
  ahb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ahb_per_ce != '0) |-> (cpu_ce && ((ahb_per_ce & ~mask_q[0]) == '0)));

  // R7
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> wr_err);

  // R7
  reject_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> $stable(mask_q));

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    // R4
    set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_we[b] |=> ((mask_q[b] & $past(wr_data)) == $past(wr_data)));
    // R5
    clr_andnot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we[b] |=> ((mask_q[b] & $past(wr_data)) == '0));
  end

endmodule

bind busclk_gate_unit bcg_checker u_bcg_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .set_we     (set_we),
  .clr_we     (clr_we),
  .wr_bad     (wr_bad),
  .wr_data    (wr_data),
  .mask_q     (mask_q),
  .wr_err     (wr_err),
  .cpu_ce     (cpu_ce),
  .apb_ce     (apb_ce),
  .ahb_per_ce (ahb_per_ce)
);

// File: tb/test_busclk_gate_unit.sv
module test_busclk_gate_unit;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_op = 2'd0;
  logic [2:0]   wr_sel = 3'd0;
  logic [W-1:0] wr_data = '0;
  logic         wr_err, cpu_ce, ahb_ce;
  logic [2:0]   apb_ce;
  logic [W-1:0] ahb_per_ce, apba_per_ce, apbb_per_ce, apbc_per_ce;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  busclk_gate_unit i_busclk_gate_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_sel(wr_sel),
    .wr_data(wr_data), .wr_err(wr_err), .cpu_ce(cpu_ce), .ahb_ce(ahb_ce),
    .apb_ce(apb_ce), .ahb_per_ce(ahb_per_ce), .apba_per_ce(apba_per_ce),
    .apbb_per_ce(apbb_per_ce), .apbc_per_ce(apbc_per_ce)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic pick(input int w);
    case (w)
      0: return cpu_ce;
      1: return apb_ce[0];
      2: return apb_ce[1];
      default: return apb_ce[2];
    endcase
  endfunction

  // cycles between two consecutive pulses of output w
  task automatic interval(input int w, output int d);
    int g = 0;
    do begin @(negedge clk); g++; end while (!pick(w) && g < 70000);
    d = 0;
    do begin @(negedge clk); d++; end while (!pick(w) && d < 70000);
  endtask

  task automatic wr(input logic [1:0] op, input logic [2:0] sel, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_op = op; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R9 ahb mask", ahb_per_ce, 8'hFF);
    check("R9 apba mask", apba_per_ce, 8'hFF);
    check("R9 apbb mask", apbb_per_ce, 8'hFF);
    check("R9 apbc mask", apbc_per_ce, 8'hFF);
    check("R9 no error", wr_err, 0);
  endtask

  task automatic t_set;
    wr(2'd1, 3'd0, 8'hFF);
    check("R5 clear all / R6 gated", ahb_per_ce, 8'h00);
    wr(2'd0, 3'd0, 8'h05);
    check("R4 set sparse", ahb_per_ce, 8'h05);
    wr(2'd0, 3'd0, 8'h00);
    check("R4 set zero no change", ahb_per_ce, 8'h05);
    wr(2'd0, 3'd0, 8'h30);
    check("R4 set ORs", ahb_per_ce, 8'h35);
  endtask

  task automatic t_clear;
    wr(2'd1, 3'd2, 8'h0A);
    check("R5 clear sparse", apbb_per_ce, 8'hF5);
    wr(2'd1, 3'd2, 8'h00);
    check("R5 clear zero no change", apbb_per_ce, 8'hF5);
    check("R7 routing apba untouched", apba_per_ce, 8'hFF);
    check("R7 routing apbc untouched", apbc_per_ce, 8'hFF);
  endtask

  task automatic t_reject;
    wr(2'd1, 3'd5, 8'hFF);
    check("R7 bad sel flag", wr_err, 1);
    check("R7 bad sel ahb", ahb_per_ce, 8'h35);
    check("R7 bad sel apbb", apbb_per_ce, 8'hF5);
    wr(2'd3, 3'd1, 8'hFF);
    check("R7 bad op flag", wr_err, 1);
    check("R7 bad op apba", apba_per_ce, 8'hFF);
    wr(2'd0, 3'd0, 8'h00);
    check("R7 accepted no flag", wr_err, 0);
  endtask

  task automatic t_main_div;
    int d;
    int codes[4] = '{0, 2, 3, 7};
    foreach (codes[i]) begin
      wr(2'd2, 3'd0, W'(codes[i]));
      repeat (140) @(negedge clk);
      interval(0, d);
      check($sformatf("R1 main code %0d", codes[i]), d, 1 << codes[i]);
    end
  endtask

  task automatic t_ahb_same;
    int mism = 0;
    repeat (300) begin
      @(negedge clk);
      if (cpu_ce !== ahb_ce) mism++;
    end
    check("R2 cpu/ahb mismatches", mism, 0);
  endtask

  task automatic t_switch;
    int d;
    int odd = 0;
    int longs = 0;
    wr(2'd2, 3'd0, 8'd1);
    repeat (140) @(negedge clk);
    wr(2'd2, 3'd0, 8'd3);
    for (int i = 0; i < 60; i++) begin
      interval(0, d);
      if (d == 8) longs++;
      else if (d != 2) odd++;
    end
    check("R8 no foreign interval", odd, 0);
    check("R8 new period reached", longs > 0, 1);
    wr(2'd2, 3'd0, 8'd1);
    repeat (140) @(negedge clk);
  endtask

  task automatic t_apb;
    int d;
    wr(2'd2, 3'd1, 8'd2);
    wr(2'd2, 3'd2, 8'd0);
    wr(2'd2, 3'd3, 8'd3);
    repeat (128 * 2 + 20) @(negedge clk);
    interval(1, d);
    check("R3 apba 2^(1+2)", d, 8);
    interval(2, d);
    check("R3 apbb 2^(1+0)", d, 2);
    interval(3, d);
    check("R3 apbc 2^(1+3)", d, 16);
    wr(2'd2, 3'd6, 8'd7);
    check("R7 bad code write flag", wr_err, 1);
    repeat (300) @(negedge clk);
    interval(1, d);
    check("R7 bad code write ignored", d, 8);
  endtask

  task automatic t_gate_apb;
    int bad = 0;
    repeat (64) begin
      @(negedge clk);
      if (apbb_per_ce !== (apb_ce[1] ? 8'hF5 : 8'h00)) bad++;
      if (ahb_per_ce !== (cpu_ce ? 8'h35 : 8'h00)) bad++;
    end
    check("R6 gated enables", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set();
    t_clear();
    t_reject();
    t_main_div();
    t_ahb_same();
    t_switch();
    t_apb();
    t_gate_apb();
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 150000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule